// File: doc/BRIEF.md
# Channel command stream parser

This block sits behind a command fetcher and interprets the 32-bit words of a channel command stream. Each word arrives through a valid/ready handshake. The parser tells header words apart from the data words that follow them. It decodes the opcode of every header and works out how many data words belong to that header. It then consumes those words one per handshake and never stalls.

The parser reports three kinds of result:
- **Register writes** carry the current class, a register offset and a data value. The offset walks according to the opcode: it can step up, stay fixed, or follow the set bits of a mask.
- **Fetch descriptors** are produced for gather and restart commands, together with their address words.
- **Sideband events** cover lock acquire/release, stream and application identifiers, and unknown extend sub-operations.

An unknown opcode raises an error pulse. The parser keeps a payload register that sets the length of the wide write commands. Fetching memory and acting on the descriptors and events are left to the surrounding logic.

Top module: `cmd_stream_parser`

## Requirements
- R1: The opcode is header bits 31:28. Code 15 is unknown. It produces a one-cycle `err_unknown` pulse, has no data words, and the next word is parsed as a header.
- R2: Opcode 0 (set-class) loads the class from bits 15:6 and takes an offset from bits 27:16 and a mask from bits 5:0. It is followed by one data word per set mask bit. Those words are written, with the new class, in ascending bit order to offset plus bit position. A zero mask changes only the class.
- R3: Opcode 1 (incrementing write) takes an offset from bits 27:16 and a count from bits 15:0. The count data words are written to offset, offset+1, and so on. A count of 0 means no data words follow.
- R4: Opcode 2 (non-incrementing write) uses the same fields as R3. Every one of its data words is written to the same offset.
- R5: Opcode 3 (masked write) takes an offset from bits 27:16 and a 16-bit mask from bits 15:0. One data word per set bit is written, in ascending bit order, to offset plus bit position.
- R6: Opcode 4 (immediate) writes {16'b0, bits 15:0} to the offset in bits 27:16 with the current class. No data words follow.
- R7: Opcode 6 (gather) is followed by one address word. After that word, the parser emits descriptor kind 0 with that word as the address, the count from bits 13:0, the offset from bits 27:16, the insert flag from bit 15 and the type from bit 14. Opcode 12 (wide gather) is followed by two address words, the first being the low half. It emits kind 1 with the 64-bit address and the count from bits 13:0; its offset, insert and type fields are zero.
- R8: Opcode 5 (restart) emits descriptor kind 2 with address {32'b0, header[27:0], 4'b0} and takes no data words. Opcode 13 (wide restart) takes two address words, low half first, and emits kind 3 with the 64-bit address.
- R9: Opcode 9 stores bits 15:0 as the payload. Opcodes 10 (wide incrementing) and 11 (wide non-incrementing) take their offset from bits 21:0 and their data-word count from the payload, with the stepping rules of R3 and R4. While the payload is still invalid (all ones, its reset value), a wide write has no data words.
- R10: Opcode 7 emits side kind 2 with value bits 21:0. Opcode 8 emits side kind 3 with value bits 7:0. Neither takes data words.
- R11: For opcode 14, bits 27:24 select the sub-operation. Sub-operation 0 emits side kind 0 (lock acquire) and 1 emits side kind 1 (lock release), each with the index in bits 7:0. Any other value emits side kind 4 with value bits 21:0.
- R12: `in_ready` is always high. Every word accepted on a rising edge produces at most one result. That result is valid for exactly the one cycle that follows the edge.
- R13: A synchronous active-low reset clears the class and the offset, sets the payload to invalid, returns the parser to the header state, and drives all result strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Command word present |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Word accepted (always high) |
| wr_valid | output | 1 | Register-write strobe |
| wr_class | output | 10 | Class of the write |
| wr_offset | output | 22 | Register offset of the write |
| wr_data | output | 32 | Write data |
| desc_valid | output | 1 | Fetch-descriptor strobe |
| desc_kind | output | 2 | 0 gather, 1 wide gather, 2 restart, 3 wide restart |
| desc_addr | output | 64 | Fetch address |
| desc_count | output | 14 | Gather word count |
| desc_offset | output | 12 | Gather register offset |
| desc_insert | output | 1 | Gather insert flag |
| desc_type | output | 1 | Gather type bit |
| side_valid | output | 1 | Sideband-event strobe |
| side_kind | output | 3 | 0 acquire, 1 release, 2 stream id, 3 app id, 4 unknown extend |
| side_value | output | 22 | Event value |
| err_unknown | output | 1 | Unknown-opcode pulse |

## Verification
Every result is registered once. A write, descriptor, side event or error caused by the word accepted on a rising edge is therefore due in the cycle right after that edge, and it is gone one cycle later unless a further word produces a result. The bench sets each word up on the falling edge and samples all outputs shortly after the next rising edge. It follows some of those samples with an idle cycle, which proves the strobe lasted one cycle. Cases with no data words are shown at the ports by sending a header word next and checking that it decodes as a header.

// File: rtl/csp_pkg.sv
// Package for the command stream parser.
// Holds the field widths, the data-phase modes, the result kinds, the decoded
// header record and a popcount helper.
package csp_pkg;
    localparam int WORD_W  = 32;
    localparam int CLASS_W = 10;
    localparam int OFF_W   = 22;
    localparam int CNT_W   = 16;
    localparam int MASK_W  = 16;
    localparam int SVAL_W  = 22;
    localparam logic [WORD_W-1:0] PAY_INVALID = '1;

    typedef enum logic [2:0] {
        M_INCR, M_NONINCR, M_MASK, M_GATHER, M_WGATHER, M_WRESTART
    } mode_e;

    typedef enum logic [1:0] {
        D_GATHER = 2'd0, D_WGATHER = 2'd1, D_RESTART = 2'd2, D_WRESTART = 2'd3
    } desc_e;

    typedef enum logic [2:0] {
        S_ACQ = 3'd0, S_REL = 3'd1, S_STREAM = 3'd2, S_APPID = 3'd3, S_EXTBAD = 3'd4
    } side_e;

    typedef struct packed {
        logic [CNT_W-1:0]   count;
        mode_e              mode;
        logic [OFF_W-1:0]   offset;
        logic [MASK_W-1:0]  mask;
        logic               set_class;
        logic [CLASS_W-1:0] cls;
        logic               set_pay;
        logic [15:0]        pay;
        logic               imm;
        logic               restart;
        logic               side;
        side_e              side_kind;
        logic [SVAL_W-1:0]  side_val;
        logic               err;
    } hdr_dec_t;

    // Number of set bits in a mask.
    function automatic logic [CNT_W-1:0] popcnt(input logic [MASK_W-1:0] m);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < MASK_W; i++) n = n + CNT_W'(m[i]);
        return n;
    endfunction
endpackage

// File: rtl/csp_decode.sv
// Header decoder: purely combinational.
// Turns one header word, together with the stored payload, into a decoded
// record. The record says how many data words follow, which data mode applies
// and which immediate results the header produces.
// Assumes: the caller presents only words that are in header position.
module csp_decode
    import csp_pkg::*;
(
    input  logic [WORD_W-1:0] hdr,
    input  logic [WORD_W-1:0] payload,
    output hdr_dec_t          dec
);
    logic [CNT_W-1:0] wide_cnt;

    // Length of a wide write: the stored payload, or zero while it is invalid.
    always_comb wide_cnt = (payload == PAY_INVALID) ? '0 : payload[CNT_W-1:0];

    // Field extraction per opcode.
    always_comb begin
        dec           = '0;
        dec.mode      = M_INCR;
        dec.side_kind = S_ACQ;
        unique case (hdr[31:28])
            4'd0: begin
                dec.set_class = 1'b1;
                dec.cls       = hdr[15:6];
                dec.offset    = OFF_W'(hdr[27:16]);
                dec.mask      = MASK_W'(hdr[5:0]);
                dec.mode      = M_MASK;
                dec.count     = popcnt(MASK_W'(hdr[5:0]));
            end
            4'd1, 4'd2: begin
                dec.offset = OFF_W'(hdr[27:16]);
                dec.count  = hdr[15:0];
                dec.mode   = (hdr[31:28] == 4'd1) ? M_INCR : M_NONINCR;
            end
            4'd3: begin
                dec.offset = OFF_W'(hdr[27:16]);
                dec.mask   = hdr[15:0];
                dec.mode   = M_MASK;
                dec.count  = popcnt(hdr[15:0]);
            end
            4'd4: begin
                dec.imm    = 1'b1;
                dec.offset = OFF_W'(hdr[27:16]);
            end
            4'd5: dec.restart = 1'b1;
            4'd6: begin
                dec.mode  = M_GATHER;
                dec.count = CNT_W'(1);
            end
            4'd7: begin
                dec.side      = 1'b1;
                dec.side_kind = S_STREAM;
                dec.side_val  = hdr[21:0];
            end
            4'd8: begin
                dec.side      = 1'b1;
                dec.side_kind = S_APPID;
                dec.side_val  = SVAL_W'(hdr[7:0]);
            end
            4'd9: begin
                dec.set_pay = 1'b1;
                dec.pay     = hdr[15:0];
            end
            4'd10, 4'd11: begin
                dec.offset = hdr[21:0];
                dec.count  = wide_cnt;
                dec.mode   = (hdr[31:28] == 4'd10) ? M_INCR : M_NONINCR;
            end
            4'd12: begin
                dec.mode  = M_WGATHER;
                dec.count = CNT_W'(2);
            end
            4'd13: begin
                dec.mode  = M_WRESTART;
                dec.count = CNT_W'(2);
            end
            4'd14: begin
                dec.side = 1'b1;
                if (hdr[27:24] == 4'd0) begin
                    dec.side_kind = S_ACQ;
                    dec.side_val  = SVAL_W'(hdr[7:0]);
                end else if (hdr[27:24] == 4'd1) begin
                    dec.side_kind = S_REL;
                    dec.side_val  = SVAL_W'(hdr[7:0]);
                end else begin
                    dec.side_kind = S_EXTBAD;
                    dec.side_val  = hdr[21:0];
                end
            end
            default: dec.err = 1'b1;
        endcase
    end
endmodule

// File: rtl/csp_lowbit.sv
// Lowest-set-bit finder used to walk a write mask in ascending order.
// Gives the isolated lowest bit as a one-hot vector and its index.
// Assumes: an all-zero mask yields index 0 and an empty one-hot vector.
module csp_lowbit #(
    parameter int W = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  mask,
    output logic [W-1:0]  onehot,
    output logic [IW-1:0] idx
);
    // Isolate the lowest set bit.
    always_comb onehot = mask & (~mask + W'(1));

    // Encode the isolated bit position.
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++)
            if (onehot[i]) idx = IW'(i);
    end

    // R5: the chosen position is always a set bit of the mask
    always_comb begin
        if (mask != '0) assert_lowbit_hit_R5: assert (mask[idx] && $onehot(onehot));
    end
endmodule

// File: rtl/cmd_stream_parser.sv
// Channel command stream parser, top level.
// Accepts one command word per handshake with no stall. It separates headers
// from their data words, issues register writes with the proper offset walk,
// and reports fetch descriptors, sideband events and unknown opcodes.
// Every result is registered and lasts the single cycle after the word that
// caused it. Assumes a synchronous active-low reset.
module cmd_stream_parser
    import csp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_data,
    output logic                in_ready,
    output logic                wr_valid,
    output logic [CLASS_W-1:0]  wr_class,
    output logic [OFF_W-1:0]    wr_offset,
    output logic [WORD_W-1:0]   wr_data,
    output logic                desc_valid,
    output logic [1:0]          desc_kind,
    output logic [63:0]         desc_addr,
    output logic [13:0]         desc_count,
    output logic [11:0]         desc_offset,
    output logic                desc_insert,
    output logic                desc_type,
    output logic                side_valid,
    output logic [2:0]          side_kind,
    output logic [SVAL_W-1:0]   side_value,
    output logic                err_unknown
);
    localparam int IDX_W = $clog2(MASK_W);

    hdr_dec_t           dec;
    logic               in_data_st;
    logic [CNT_W-1:0]   rem;
    mode_e              mode;
    logic [OFF_W-1:0]   off;
    logic [MASK_W-1:0]  mask;
    logic [CLASS_W-1:0] cls;
    logic [WORD_W-1:0]  payload;
    logic [27:0]        hold_hdr;
    logic [WORD_W-1:0]  lo_word;
    logic [MASK_W-1:0]  low_onehot;
    logic [IDX_W-1:0]   low_idx;

    // The parser never stalls.
    assign in_ready = 1'b1;

    csp_decode u_decode (
        .hdr     (in_data),
        .payload (payload),
        .dec     (dec)
    );

    csp_lowbit #(.W(MASK_W)) u_lowbit (
        .mask   (mask),
        .onehot (low_onehot),
        .idx    (low_idx)
    );

    // Parser state, stored fields and registered results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_data_st  <= 1'b0;
            rem         <= '0;
            mode        <= M_INCR;
            off         <= '0;
            mask        <= '0;
            cls         <= '0;
            payload     <= PAY_INVALID;
            hold_hdr    <= '0;
            lo_word     <= '0;
            wr_valid    <= 1'b0;
            wr_class    <= '0;
            wr_offset   <= '0;
            wr_data     <= '0;
            desc_valid  <= 1'b0;
            desc_kind   <= '0;
            desc_addr   <= '0;
            desc_count  <= '0;
            desc_offset <= '0;
            desc_insert <= 1'b0;
            desc_type   <= 1'b0;
            side_valid  <= 1'b0;
            side_kind   <= '0;
            side_value  <= '0;
            err_unknown <= 1'b0;
        end else begin
            wr_valid    <= 1'b0;
            desc_valid  <= 1'b0;
            side_valid  <= 1'b0;
            err_unknown <= 1'b0;
            if (in_valid && !in_data_st) begin
                if (dec.set_class) cls <= dec.cls;
                if (dec.set_pay) payload <= WORD_W'(dec.pay);
                off      <= dec.offset;
                mask     <= dec.mask;
                mode     <= dec.mode;
                rem      <= dec.count;
                hold_hdr <= in_data[27:0];
                if (dec.count != '0) in_data_st <= 1'b1;
                if (dec.imm) begin
                    wr_valid  <= 1'b1;
                    wr_class  <= cls;
                    wr_offset <= dec.offset;
                    wr_data   <= WORD_W'(in_data[15:0]);
                end
                if (dec.restart) begin
                    desc_valid  <= 1'b1;
                    desc_kind   <= D_RESTART;
                    desc_addr   <= {32'b0, in_data[27:0], 4'b0};
                    desc_count  <= '0;
                    desc_offset <= '0;
                    desc_insert <= 1'b0;
                    desc_type   <= 1'b0;
                end
                if (dec.side) begin
                    side_valid <= 1'b1;
                    side_kind  <= dec.side_kind;
                    side_value <= dec.side_val;
                end
                err_unknown <= dec.err;
            end else if (in_valid) begin
                rem <= rem - CNT_W'(1);
                if (rem == CNT_W'(1)) in_data_st <= 1'b0;
                unique case (mode)
                    M_INCR, M_NONINCR: begin
                        wr_valid  <= 1'b1;
                        wr_class  <= cls;
                        wr_offset <= off;
                        wr_data   <= in_data;
                        if (mode == M_INCR) off <= off + OFF_W'(1);
                    end
                    M_MASK: begin
                        wr_valid  <= 1'b1;
                        wr_class  <= cls;
                        wr_offset <= off + OFF_W'(low_idx);
                        wr_data   <= in_data;
                        mask      <= mask & ~low_onehot;
                    end
                    M_GATHER: begin
                        desc_valid  <= 1'b1;
                        desc_kind   <= D_GATHER;
                        desc_addr   <= {32'b0, in_data};
                        desc_count  <= hold_hdr[13:0];
                        desc_offset <= hold_hdr[27:16];
                        desc_insert <= hold_hdr[15];
                        desc_type   <= hold_hdr[14];
                    end
                    default: begin
                        if (rem == CNT_W'(2)) begin
                            lo_word <= in_data;
                        end else begin
                            desc_valid  <= 1'b1;
                            desc_kind   <= (mode == M_WGATHER) ? D_WGATHER : D_WRESTART;
                            desc_addr   <= {in_data, lo_word};
                            desc_count  <= (mode == M_WGATHER) ? hold_hdr[13:0] : '0;
                            desc_offset <= '0;
                            desc_insert <= 1'b0;
                            desc_type   <= 1'b0;
                        end
                    end
                endcase
            end
        end
    end

    // R12: one accepted word yields at most one result
    assert_one_result_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, desc_valid, side_valid, err_unknown}));

    // R12: a result only follows an accepted word
    assert_result_after_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid || desc_valid || side_valid || err_unknown) |-> $past(in_valid));

    // R1: the error pulse comes only from an opcode-15 header
    assert_err_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err_unknown |-> $past(in_valid && !in_data_st && in_data[31:28] == 4'hF));

    // R3: the data phase always has words left to take
    assert_rem_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_data_st |-> (rem != '0));

    // R7: gather descriptors are issued only from the data phase
    assert_gather_from_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && (desc_kind == D_GATHER || desc_kind == D_WGATHER)) |-> $past(in_data_st));
endmodule

// File: tb/cmd_stream_parser_test.sv
module cmd_stream_parser_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        wr_valid;
    logic [9:0]  wr_class;
    logic [21:0] wr_offset;
    logic [31:0] wr_data;
    logic        desc_valid;
    logic [1:0]  desc_kind;
    logic [63:0] desc_addr;
    logic [13:0] desc_count;
    logic [11:0] desc_offset;
    logic        desc_insert;
    logic        desc_type;
    logic        side_valid;
    logic [2:0]  side_kind;
    logic [21:0] side_value;
    logic        err_unknown;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cmd_stream_parser uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .wr_valid(wr_valid), .wr_class(wr_class),
        .wr_offset(wr_offset), .wr_data(wr_data), .desc_valid(desc_valid),
        .desc_kind(desc_kind), .desc_addr(desc_addr), .desc_count(desc_count),
        .desc_offset(desc_offset), .desc_insert(desc_insert), .desc_type(desc_type),
        .side_valid(side_valid), .side_kind(side_kind), .side_value(side_value),
        .err_unknown(err_unknown)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present a word on the falling edge; sample just after the accepting edge.
    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic expect_wr(input string req, input logic [9:0] c, input logic [21:0] o,
                             input logic [31:0] d);
        check(req, {desc_valid, side_valid, err_unknown, wr_valid, wr_class, wr_offset, wr_data},
              {1'b0, 1'b0, 1'b0, 1'b1, c, o, d});
    endtask

    task automatic expect_none(input string req);
        check(req, {wr_valid, desc_valid, side_valid, err_unknown}, 4'b0);
    endtask

    task automatic expect_desc(input string req, input logic [1:0] k, input logic [63:0] a,
                               input logic [13:0] n, input logic [11:0] o, input logic ins,
                               input logic ty);
        check(req, {wr_valid, desc_valid, desc_kind, desc_addr, desc_count, desc_offset,
                    desc_insert, desc_type},
              {1'b0, 1'b1, k, a, n, o, ins, ty});
    endtask

    task automatic expect_side(input string req, input logic [2:0] k, input logic [21:0] v);
        check(req, {wr_valid, side_valid, side_kind, side_value}, {1'b0, 1'b1, k, v});
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        expect_none("R13 reset strobes");
        check("R12 in_ready high", in_ready, 1'b1);
        send(32'h4005_0001);
        expect_wr("R13 class cleared", 10'h0, 22'h5, 32'h1);
    endtask

    task automatic t_setclass();
        send(32'h0000_0000 | (32'h123 << 6));
        expect_none("R2 class-only header");
        send(32'h4005_BEEF);
        expect_wr("R2 R6 imm with new class", 10'h123, 22'h005, 32'h0000_BEEF);
        idle();
        expect_none("R12 pulse one cycle");
        send(32'h0010_0000 | (32'h02A << 6) | 32'h25);
        expect_none("R2 header no result");
        send(32'hA1);
        expect_wr("R2 bit0", 10'h02A, 22'h10, 32'hA1);
        send(32'hA2);
        expect_wr("R2 bit2", 10'h02A, 22'h12, 32'hA2);
        send(32'hA3);
        expect_wr("R2 bit5", 10'h02A, 22'h15, 32'hA3);
        send(32'h4001_0002);
        expect_wr("R2 back to header", 10'h02A, 22'h1, 32'h2);
    endtask

    task automatic t_incr();
        send(32'h1020_0003);
        expect_none("R3 header");
        for (int i = 0; i < 3; i++) begin
            send(32'h100 + i);
            expect_wr("R3 step", 10'h02A, 22'h20 + i, 32'h100 + i);
        end
        send(32'h1033_0000);
        expect_none("R3 zero count");
        send(32'h4007_0009);
        expect_wr("R3 zero count then header", 10'h02A, 22'h7, 32'h9);
    endtask

    task automatic t_nonincr();
        send(32'h2030_0002);
        send(32'h55);
        expect_wr("R4 first", 10'h02A, 22'h30, 32'h55);
        send(32'h66);
        expect_wr("R4 second same offset", 10'h02A, 22'h30, 32'h66);
        send(32'h4008_0001);
        expect_wr("R4 header after", 10'h02A, 22'h8, 32'h1);
    endtask

    task automatic t_mask();
        send(32'h3040_8001);
        send(32'h11);
        expect_wr("R5 bit0", 10'h02A, 22'h40, 32'h11);
        send(32'h22);
        expect_wr("R5 bit15", 10'h02A, 22'h4F, 32'h22);
        send(32'h4009_0003);
        expect_wr("R5 header after", 10'h02A, 22'h9, 32'h3);
    endtask

    task automatic t_gather();
        send(32'h6007_8123);
        expect_none("R7 gather header");
        send(32'hDEAD_0000);
        expect_desc("R7 gather", 2'd0, 64'hDEAD_0000, 14'h0123, 12'h007, 1'b1, 1'b0);
        send(32'hC000_0010);
        send(32'h1111_2222);
        expect_none("R7 wide gather low word");
        send(32'h3333_4444);
        expect_desc("R7 wide gather", 2'd1, 64'h3333_4444_1111_2222, 14'h10, 12'h0, 1'b0, 1'b0);
    endtask

    task automatic t_restart();
        send(32'h5ABC_DEF1);
        expect_desc("R8 restart", 2'd2, 64'hABCD_EF10, 14'h0, 12'h0, 1'b0, 1'b0);
        send(32'hD000_0000);
        send(32'h0000_0010);
        send(32'h0000_0002);
        expect_desc("R8 wide restart", 2'd3, 64'h0000_0002_0000_0010, 14'h0, 12'h0, 1'b0, 1'b0);
    endtask

    task automatic t_payload();
        do_reset();
        send(32'hA000_0123);
        expect_none("R9 invalid payload header");
        send(32'h4002_0004);
        expect_wr("R9 invalid payload no data", 10'h0, 22'h2, 32'h4);
        send(32'h9000_0002);
        expect_none("R9 set payload");
        send(32'hA012_3456);
        send(32'h71);
        expect_wr("R9 wide incr 0", 10'h0, 22'h123456, 32'h71);
        send(32'h72);
        expect_wr("R9 wide incr 1", 10'h0, 22'h123457, 32'h72);
        send(32'hB000_0050);
        send(32'h81);
        expect_wr("R9 wide nonincr 0", 10'h0, 22'h50, 32'h81);
        send(32'h82);
        expect_wr("R9 wide nonincr 1", 10'h0, 22'h50, 32'h82);
        send(32'h4003_0005);
        expect_wr("R9 header after wide", 10'h0, 22'h3, 32'h5);
    endtask

    task automatic t_side();
        send(32'h7012_3456);
        expect_side("R10 stream id", 3'd2, 22'h123456);
        send(32'h8000_00AB);
        expect_side("R10 app id", 3'd3, 22'hAB);
        send(32'hE000_0005);
        expect_side("R11 acquire", 3'd0, 22'h5);
        send(32'hE100_0007);
        expect_side("R11 release", 3'd1, 22'h7);
        send(32'hE500_1234);
        expect_side("R11 unknown sub-op", 3'd4, 22'h001234);
    endtask

    task automatic t_unknown();
        send(32'hF000_0003);
        check("R1 error pulse", {err_unknown, wr_valid}, 2'b10);
        idle();
        check("R1 pulse ends", err_unknown, 1'b0);
        send(32'h400A_0006);
        expect_wr("R1 next is header", 10'h0, 22'hA, 32'h6);
    endtask

    task automatic t_reset_mid();
        send(32'h0000_0000 | (32'h3FF << 6));
        send(32'h1060_0005);
        send(32'h1);
        expect_wr("R13 pre-reset write", 10'h3FF, 22'h60, 32'h1);
        do_reset();
        send(32'h400B_0007);
        expect_wr("R13 mid-stream reset", 10'h0, 22'hB, 32'h7);
    endtask

    initial begin
        t_reset();
        t_setclass();
        t_incr();
        t_nonincr();
        t_mask();
        t_gather();
        t_restart();
        t_payload();
        t_side();
        t_unknown();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule